// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller

This block is the test-port controller of a device that offers a reduced boundary-scan instruction set. A serial test clock and a mode-select line walk the standard sixteen-state controller; serial data enters on the test data input and leaves on the test data output, either through a 3-bit instruction register or through one of three data registers: a one-bit bypass stage, a 32-bit identification register, or a capture chain that snapshots a parameterised vector of pin values.

Five behaviours are decoded from the active instruction. Bypass, identification and sample work in the usual way. A sample variant captures like sample and also raises a signal that forces the functional output drivers to high impedance. An external-test opcode selects the capture chain. The unused opcodes act as bypass. No update register sits behind the capture chain, so the update-DR state never changes anything facing the pins. The real boundary cells and the pin multiplexing live outside this block.

Top module: `scan_tap_top`

## Requirements
- R1: While reset is held and right after it is released, the controller is in Test-Logic-Reset, the active instruction is the identification opcode 3'b001, tdoEn is 0, tdo is 0 and outputsHighZ is 0.
- R2: The state changes once per rising tck edge, following the standard sixteen-state graph with tms as the branch input, including the pause and exit-2 loops of both scan columns.
- R3: Five consecutive rising tck edges with tms high bring the controller to Test-Logic-Reset from any state, and the active instruction then becomes the identification opcode.
- R4: Capture-IR loads 3'b001 into the instruction shift stage. Shift-IR moves it toward tdo LSB first, with tdi entering at bit 2.
- R5: The identification register is selected after reset. It captures the 32-bit ID_VALUE with bit 0 forced to 1 and shifts it out LSB first.
- R6: Opcode 3'b111 selects a single bypass bit that captures 0, so the shifted output equals the tdi stream delayed by one bit.
- R7: The reserved opcodes 3'b011, 3'b101 and 3'b110 are accepted and behave exactly like bypass.
- R8: Opcode 3'b100 selects the capture chain. Capture-DR loads pinCapture, and bit 0 leaves first.
- R9: Opcode 3'b010 captures like R8 and holds outputsHighZ at 1 for as long as it is the active instruction, and for no other opcode.
- R10: Update-DR leaves outputsHighZ unchanged, and data shifted into the capture chain never reaches a later capture, which again reflects pinCapture.
- R11: tdo and tdoEn change only on falling tck edges. tdoEn is 1 only in Shift-IR and Shift-DR, and tdo is 0 whenever tdoEn is 0.
- R12: Opcode 3'b000 selects the capture chain with outputsHighZ at 0.
- R13: The active instruction changes only on the edge that leaves Update-IR or on an edge in Test-Logic-Reset, so the value being shifted into the instruction register has no effect until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| pinCapture | input | BSR_W | Pin values captured by the scan chain |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdoEn | output | 1 | Output enable for tdo |
| outputsHighZ | output | 1 | Forces the functional output drivers to high impedance |

## Verification
Two things can land on one edge: a new pinCapture value and the Capture-DR edge that must take it. The same holds for the last edge of a five-ones reset walk and the drop of the high-impedance force that the sample-variant instruction had raised. The bench changes pinCapture in the very cycle of the capture edge, and it leaves a shift column with tms held high while that instruction is active. A behavioural reference model predicts tdo, tdoEn and outputsHighZ after every falling edge and judges both cases, and the scanned-out words are then compared with values computed from the requirements.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    sReset   = 4'hF,
    sIdle    = 4'hC,
    sSelDr   = 4'h7,
    sCapDr   = 4'h6,
    sShDr    = 4'h2,
    sEx1Dr   = 4'h1,
    sPauseDr = 4'h3,
    sEx2Dr   = 4'h0,
    sUpdDr   = 4'h5,
    sSelIr   = 4'h4,
    sCapIr   = 4'hE,
    sShIr    = 4'hA,
    sEx1Ir   = 4'h9,
    sPauseIr = 4'hB,
    sEx2Ir   = 4'h8,
    sUpdIr   = 4'hD
  } tapState_t;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

  typedef enum logic [1:0] {
    selBypass,
    selIdent,
    selChain
  } drSel_t;

  typedef struct packed {
    logic resetIr;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
  } tapStrobe_t;

endpackage

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rstN,
  input  logic       tms,
  output tapState_t  curState,
  output tapStrobe_t strobe
);

  tapState_t nxtState;

  always_comb begin
    nxtState = curState;
    unique case (curState)
      sReset:   nxtState = tms ? sReset : sIdle;
      sIdle:    nxtState = tms ? sSelDr : sIdle;
      sSelDr:   nxtState = tms ? sSelIr : sCapDr;
      sCapDr:   nxtState = tms ? sEx1Dr : sShDr;
      sShDr:    nxtState = tms ? sEx1Dr : sShDr;
      sEx1Dr:   nxtState = tms ? sUpdDr : sPauseDr;
      sPauseDr: nxtState = tms ? sEx2Dr : sPauseDr;
      sEx2Dr:   nxtState = tms ? sUpdDr : sShDr;
      sUpdDr:   nxtState = tms ? sSelDr : sIdle;
      sSelIr:   nxtState = tms ? sReset : sCapIr;
      sCapIr:   nxtState = tms ? sEx1Ir : sShIr;
      sShIr:    nxtState = tms ? sEx1Ir : sShIr;
      sEx1Ir:   nxtState = tms ? sUpdIr : sPauseIr;
      sPauseIr: nxtState = tms ? sEx2Ir : sPauseIr;
      sEx2Ir:   nxtState = tms ? sUpdIr : sShIr;
      sUpdIr:   nxtState = tms ? sSelDr : sIdle;
      default:  nxtState = sReset;
    endcase
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) curState <= sReset;
    else       curState <= nxtState;
  end

  always_comb begin
    strobe.resetIr   = (curState == sReset);
    strobe.captureIr = (curState == sCapIr);
    strobe.shiftIr   = (curState == sShIr);
    strobe.updateIr  = (curState == sUpdIr);
    strobe.captureDr = (curState == sCapDr);
    strobe.shiftDr   = (curState == sShDr);
  end

endmodule

// File: rtl/scan_tap_datapath.sv
module scan_tap_datapath
  import scan_tap_pkg::*;
#(
  parameter int          BSR_W    = 8,
  parameter logic [31:0] ID_VALUE = 32'h4B2D_91E7
) (
  input  logic            tck,
  input  logic            rstN,
  input  logic            tdi,
  input  tapStrobe_t      strobe,
  input  logic [BSR_W-1:0] pinCapture,
  output logic [IR_W-1:0] activeIr,
  output logic [IR_W-1:0] irShift,
  output logic            tdo,
  output logic            tdoEn,
  output logic            outputsHighZ
);

  localparam int          ID_W    = 32;
  localparam logic [ID_W-1:0] ID_WORD = {ID_VALUE[ID_W-1:1], 1'b1};

  drSel_t           drSel;
  logic             bypassBit;
  logic [ID_W-1:0]  idShift;
  logic [BSR_W-1:0] chainBits;
  logic [BSR_W-1:0] chainShiftIn;
  logic             chainCap;
  logic             chainSh;
  logic             drLsb;

  // Decode of the active instruction; unlisted codes fall to bypass
  always_comb begin
    unique case (activeIr)
      OP_IDCODE:                       drSel = selIdent;
      OP_SAMPLE, OP_SAMPLEZ, OP_EXTEST: drSel = selChain;
      default:                         drSel = selBypass;
    endcase
  end

  // Instruction register: shift stage plus active copy
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      irShift  <= IR_CAPTURE_PAT;
      activeIr <= OP_IDCODE;
    end else begin
      if (strobe.captureIr)    irShift <= IR_CAPTURE_PAT;
      else if (strobe.shiftIr) irShift <= {tdi, irShift[IR_W-1:1]};
      if (strobe.resetIr)       activeIr <= OP_IDCODE;
      else if (strobe.updateIr) activeIr <= irShift;
    end
  end

  // Bypass stage
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) bypassBit <= 1'b0;
    else if (drSel == selBypass) begin
      if (strobe.captureDr)    bypassBit <= 1'b0;
      else if (strobe.shiftDr) bypassBit <= tdi;
    end
  end

  // Identification register
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) idShift <= ID_WORD;
    else if (drSel == selIdent) begin
      if (strobe.captureDr)    idShift <= ID_WORD;
      else if (strobe.shiftDr) idShift <= {tdi, idShift[ID_W-1:1]};
    end
  end

  // Capture chain, one cell per pin; no update stage behind it
  assign chainCap = strobe.captureDr && (drSel == selChain);
  assign chainSh  = strobe.shiftDr   && (drSel == selChain);

  for (genvar gi = 0; gi < BSR_W; gi++) begin : g_cell
    if (gi == BSR_W - 1) begin : g_head
      assign chainShiftIn[gi] = tdi;
    end else begin : g_body
      assign chainShiftIn[gi] = chainBits[gi+1];
    end

    always_ff @(posedge tck or negedge rstN) begin
      if (!rstN)         chainBits[gi] <= 1'b0;
      else if (chainCap) chainBits[gi] <= pinCapture[gi];
      else if (chainSh)  chainBits[gi] <= chainShiftIn[gi];
    end
  end

  always_comb begin
    unique case (drSel)
      selIdent: drLsb = idShift[0];
      selChain: drLsb = chainBits[0];
      default:  drLsb = bypassBit;
    endcase
  end

  // Serial output retimed to the falling edge
  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= strobe.shiftIr | strobe.shiftDr;
      if (strobe.shiftIr)      tdo <= irShift[0];
      else if (strobe.shiftDr) tdo <= drLsb;
      else                     tdo <= 1'b0;
    end
  end

  assign outputsHighZ = (activeIr == OP_SAMPLEZ);

endmodule

// File: rtl/scan_tap_top.sv
module scan_tap_top
  import scan_tap_pkg::*;
#(
  parameter int          BSR_W    = 8,
  parameter logic [31:0] ID_VALUE = 32'h4B2D_91E7
) (
  input  logic             tck,
  input  logic             rstN,
  input  logic             tms,
  input  logic             tdi,
  input  logic [BSR_W-1:0] pinCapture,
  output logic             tdo,
  output logic             tdoEn,
  output logic             outputsHighZ
);

  tapState_t       curState;
  tapStrobe_t      strobe;
  logic [IR_W-1:0] activeIr;
  logic [IR_W-1:0] irShift;

  scan_tap_ctrl ctrl_i (
    .tck      (tck),
    .rstN     (rstN),
    .tms      (tms),
    .curState (curState),
    .strobe   (strobe)
  );

  scan_tap_datapath #(
    .BSR_W    (BSR_W),
    .ID_VALUE (ID_VALUE)
  ) dp_i (
    .tck          (tck),
    .rstN         (rstN),
    .tdi          (tdi),
    .strobe       (strobe),
    .pinCapture   (pinCapture),
    .activeIr     (activeIr),
    .irShift      (irShift),
    .tdo          (tdo),
    .tdoEn        (tdoEn),
    .outputsHighZ (outputsHighZ)
  );

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
(
  input logic            tck,
  input logic            rstN,
  input logic            tms,
  input tapState_t       curState,
  input logic [IR_W-1:0] activeIr,
  input logic [IR_W-1:0] irShift,
  input logic            tdo,
  input logic            tdoEn,
  input logic            outputsHighZ
);

  logic [2:0] onesRun;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)            onesRun <= 3'd0;
    else if (!tms)        onesRun <= 3'd0;
    else if (onesRun < 5) onesRun <= onesRun + 3'd1;
  end

  AST_RESET_LOADS_ID: assert property (@(posedge tck) disable iff (!rstN)
    curState == sReset |=> activeIr == OP_IDCODE); // R1

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!rstN)
    onesRun >= 3'd5 |-> curState == sReset); // R3

  AST_CAPIR_PATTERN: assert property (@(posedge tck) disable iff (!rstN)
    curState == sCapIr |=> irShift == IR_CAPTURE_PAT); // R4

  AST_HIGHZ_FROM_UPDATE: assert property (@(posedge tck) disable iff (!rstN)
    $rose(outputsHighZ) |-> $past(curState) == sUpdIr); // R9

  AST_UPDDR_NO_EFFECT: assert property (@(posedge tck) disable iff (!rstN)
    curState == sUpdDr |=> $stable(outputsHighZ)); // R10

  AST_ENABLE_IN_SHIFT: assert property (@(posedge tck) disable iff (!rstN)
    tdoEn == (curState == sShDr || curState == sShIr)); // R11

  AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!rstN)
    !tdoEn |-> !tdo); // R11

  AST_IR_HOLDS: assert property (@(posedge tck) disable iff (!rstN)
    (curState != sUpdIr && curState != sReset) |=> $stable(activeIr)); // R13

endmodule

bind scan_tap_top scan_tap_chk chk_i (
  .tck          (tck),
  .rstN         (rstN),
  .tms          (tms),
  .curState     (curState),
  .activeIr     (activeIr),
  .irShift      (irShift),
  .tdo          (tdo),
  .tdoEn        (tdoEn),
  .outputsHighZ (outputsHighZ)
);

// File: tb/scan_tap_top_tb_top.sv
module scan_tap_top_tb_top;

  localparam int          W     = 8;
  localparam logic [31:0] TB_ID = 32'h4B2D_91E6; // bit 0 deliberately 0
  localparam logic [31:0] ID_EXP = 32'h4B2D_91E7;

  // reference model state numbering (bench-local)
  localparam int M_RST = 0, M_IDLE = 1, M_SDR = 2, M_CDR = 3, M_SHDR = 4,
                 M_E1DR = 5, M_PDR = 6, M_E2DR = 7, M_UDR = 8, M_SIR = 9,
                 M_CIR = 10, M_SHIR = 11, M_E1IR = 12, M_PIR = 13,
                 M_E2IR = 14, M_UIR = 15;

  logic tck = 1'b0;
  logic rstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [W-1:0] pins = '0;
  logic tdo, tdoEn, outputsHighZ;

  int nCmp = 0;
  int nBad = 0;
  string curReq = "R1";
  bit finished = 0;

  int           mState;
  logic [2:0]   mIrSh, mIr;
  logic         mByp;
  logic [31:0]  mId;
  logic [W-1:0] mBnd;
  logic         lastTdo;

  scan_tap_top #(.BSR_W(W), .ID_VALUE(TB_ID)) dut_i (
    .tck(tck), .rstN(rstN), .tms(tms), .tdi(tdi), .pinCapture(pins),
    .tdo(tdo), .tdoEn(tdoEn), .outputsHighZ(outputsHighZ)
  );

  always #10 tck = ~tck;

  function automatic int nextOf(int s, logic m);
    int t0[16] = '{M_IDLE, M_IDLE, M_CDR, M_SHDR, M_SHDR, M_PDR, M_PDR, M_SHDR,
                   M_IDLE, M_CIR, M_SHIR, M_SHIR, M_PIR, M_PIR, M_SHIR, M_IDLE};
    int t1[16] = '{M_RST, M_SDR, M_SIR, M_E1DR, M_E1DR, M_UDR, M_E2DR, M_UDR,
                   M_SDR, M_RST, M_E1IR, M_E1IR, M_UIR, M_E2IR, M_UIR, M_SDR};
    return m ? t1[s] : t0[s];
  endfunction

  function automatic int selOf(logic [2:0] ir); // 0 bypass, 1 id, 2 chain
    if (ir == 3'b001) return 1;
    if (ir == 3'b100 || ir == 3'b010 || ir == 3'b000) return 2;
    return 0;
  endfunction

  task automatic modelReset();
    mState = M_RST; mIrSh = 3'b001; mIr = 3'b001;
    mByp = 0; mId = ID_EXP; mBnd = '0;
  endtask

  task automatic modelEdge(logic m, logic d);
    int sel = selOf(mIr);
    case (mState)
      M_CIR:  mIrSh = 3'b001;
      M_SHIR: mIrSh = {d, mIrSh[2:1]};
      M_UIR:  mIr = mIrSh;
      M_RST:  mIr = 3'b001;
      M_CDR: begin
        if (sel == 0) mByp = 0; else if (sel == 1) mId = ID_EXP; else mBnd = pins;
      end
      M_SHDR: begin
        if (sel == 0) mByp = d;
        else if (sel == 1) mId = {d, mId[31:1]};
        else mBnd = {d, mBnd[W-1:1]};
      end
      default: ;
    endcase
    mState = nextOf(mState, m);
  endtask

  task automatic compareOutputs();
    logic eTdo, eEn, eZ;
    int sel = selOf(mIr);
    eEn = (mState == M_SHIR) || (mState == M_SHDR);
    eTdo = 1'b0;
    if (mState == M_SHIR) eTdo = mIrSh[0];
    else if (mState == M_SHDR) eTdo = (sel == 0) ? mByp : (sel == 1) ? mId[0] : mBnd[0];
    eZ = (mIr == 3'b010);
    nCmp++;
    if (tdo !== eTdo || tdoEn !== eEn || outputsHighZ !== eZ) begin
      nBad++;
      $display("FAIL %s (R11 cycle) tdo/en/hz actual=%b%b%b expected=%b%b%b",
               curReq, tdo, tdoEn, outputsHighZ, eTdo, eEn, eZ);
    end
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic m, logic d);
    tms = m; tdi = d;
    @(posedge tck);
    modelEdge(m, d);
    @(negedge tck);
    #1;
    lastTdo = tdo;
    compareOutputs();
  endtask

  task automatic loadIr(logic [2:0] op);
    logic [2:0] got;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    got[0] = lastTdo;
    for (int i = 0; i < 3; i++) begin
      step(i == 2, op[i]);
      if (i < 2) got[i+1] = lastTdo;
    end
    check("R4 capture-IR pattern", {61'd0, got}, 64'd1);
    step(1, 0); step(0, 0);
  endtask

  task automatic scanDr(int n, logic [63:0] din, logic [W-1:0] capPins,
                        int pauseAt, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0);
    pins = capPins;              // changes on the capture edge itself
    step(0, 0);
    dout[0] = lastTdo;
    for (int i = 0; i < n; i++) begin
      if (i == pauseAt && i < n - 1) begin
        step(1, din[i]); step(0, 0); step(0, 0); step(1, 0); step(0, 0);
        dout[i+1] = lastTdo;
      end else begin
        step(i == n - 1, din[i]);
        if (i < n - 1) dout[i+1] = lastTdo;
      end
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired in %s", curReq);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [63:0] out;
    modelReset();
    repeat (3) @(negedge tck);
    #1;
    curReq = "R1";
    check("R1 reset tdoEn", {63'd0, tdoEn}, 64'd0);
    check("R1 reset tdo", {63'd0, tdo}, 64'd0);
    check("R1 reset highZ", {63'd0, outputsHighZ}, 64'd0);
    rstN = 1'b1;
    step(1, 0);
    step(0, 0);

    curReq = "R5";
    scanDr(32, 64'h0, 8'h00, -1, out);
    check("R5 ID after reset", {32'd0, out[31:0]}, {32'd0, ID_EXP});

    curReq = "R6";
    loadIr(3'b111);
    scanDr(8, 64'hA5, 8'h00, -1, out);
    check("R6 bypass delay", {56'd0, out[7:0]}, 64'h4A);

    curReq = "R7";
    loadIr(3'b011);
    scanDr(8, 64'h96, 8'h00, -1, out);
    check("R7 reserved 011 as bypass", {56'd0, out[7:0]}, 64'h2C);
    loadIr(3'b101);
    scanDr(8, 64'h3F, 8'h00, -1, out);
    check("R7 reserved 101 as bypass", {56'd0, out[7:0]}, 64'h7E);
    loadIr(3'b110);
    scanDr(8, 64'h81, 8'h00, -1, out);
    check("R7 reserved 110 as bypass", {56'd0, out[7:0]}, 64'h02);

    curReq = "R8";
    pins = 8'hFF;
    loadIr(3'b100);
    scanDr(8, 64'hFF, 8'h3C, -1, out);
    check("R8 sample capture", {56'd0, out[7:0]}, 64'h3C);

    curReq = "R10";
    check("R10 highZ after update-DR", {63'd0, outputsHighZ}, 64'd0);
    scanDr(8, 64'h00, 8'hC3, -1, out);
    check("R10 recapture shows pins", {56'd0, out[7:0]}, 64'hC3);

    curReq = "R2";
    scanDr(8, 64'h00, 8'h5A, 3, out);
    check("R2 pause loop keeps data", {56'd0, out[7:0]}, 64'h5A);
    scanDr(32, 64'h0, 8'h00, -1, out); // still sample: chain, bits above 7 = shifted zeros
    check("R2 chain length", {56'd0, out[7:0]}, 64'h00);

    curReq = "R13";
    loadIr(3'b010);
    curReq = "R9";
    check("R9 highZ with sample-z", {63'd0, outputsHighZ}, 64'd1);
    scanDr(8, 64'h00, 8'h69, -1, out);
    check("R9 sample-z capture", {56'd0, out[7:0]}, 64'h69);

    curReq = "R12";
    loadIr(3'b000);
    check("R12 highZ low with extest", {63'd0, outputsHighZ}, 64'd0);
    scanDr(8, 64'h00, 8'hE1, -1, out);
    check("R12 extest chain", {56'd0, out[7:0]}, 64'hE1);

    curReq = "R3";
    loadIr(3'b010);
    step(1, 0); step(0, 0); step(0, 0); step(0, 1);
    repeat (5) step(1, 0);
    step(0, 0);
    check("R3 highZ released", {63'd0, outputsHighZ}, 64'd0);
    scanDr(32, 64'h0, 8'h00, -1, out);
    check("R3 ID after five ones", {32'd0, out[31:0]}, {32'd0, ID_EXP});

    loadIr(3'b111);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0); step(1, 1); step(0, 0);
    repeat (5) step(1, 0);
    step(0, 0);
    scanDr(32, 64'h0, 8'h00, -1, out);
    check("R3 ID after reset from pause-IR", {32'd0, out[31:0]}, {32'd0, ID_EXP});

    curReq = "R11";
    check("R11 tdoEn idle", {63'd0, tdoEn}, 64'd0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule